// File: doc/BRIEF.md
# Indexed CMOS Register Access Port

This block gives a host a byte-wide view of a 256-byte configuration space through four consecutive I/O addresses. There are two address/data pairs, one per bank of 128 bytes. Software first writes a byte offset to a pair's pointer port. It then reads or writes the addressed byte through that pair's data port. The pointer keeps its value, so repeated data accesses reach the same byte.

The lower bank holds the clock and calendar fields, the century byte and three control registers. Those indices are not stored here. They are forwarded to the timekeeping block over a simple select/write/read-back side interface. The block does keep one status register itself, which carries a "contents valid" indication. Every other offset, in both banks, is general-purpose storage owned by this block and cleared by reset.

When the host reads the interrupt-flag register through the data port, the block raises a one-cycle strobe. The interrupt logic uses that strobe to clear its flags.

Top module: `cmos_port`

## Requirements
- R1: While `rst_n_i` is low at a clock edge, both pointers, all storage bytes, `io_rdata_o` and `flag_clr_o` are cleared to zero. A storage byte read after reset returns 0x00.
- R2: A write to base+0 loads bits 6:0 of the write data into the lower pointer, and bit 7 is ignored. A write to base+2 loads the upper pointer the same way. Each pointer keeps its value across any number of data-port accesses until its own pointer port is written again.
- R3: When the selected index is a storage byte, a write to the data port (base+1 lower, base+3 upper) stores the data there. A read of the data port loads that byte into `io_rdata_o` at the next clock edge. `io_rdata_o` then holds until the next read inside the window.
- R4: The upper bank (base+2/base+3) is a separate set of 128 storage bytes, indices 0 to 127, and none of them is special. The same index in the two banks names two independent bytes.
- R5: Lower-bank indices 0 to 12 and index 0x32 (the clock fields, control registers A to C, and the century byte) are routed out. During a data-port access to one of them, `tk_sel_o` is high in the same cycle and `tk_idx_o` equals the index. `tk_we_o` is high only for a write, and `tk_wdata_o` carries the data. A read returns the `tk_rdata_i` value present in the read cycle.
- R6: Lower-bank index 13 is a local status register. A read returns `vrt_i` in bit 7 and zeros in bits 6:0. Writes to it change nothing and are not routed out.
- R7: A data-port read of lower-bank index 12 raises `flag_clr_o` for exactly the one cycle that follows the read. Writes to index 12, reads of other indices, and reads of upper-bank index 12 leave it low.
- R8: Accesses whose `io_addr_i` lies outside base..base+3 have no effect. They change neither pointer nor any storage byte, do not raise `tk_sel_o`, and leave `io_rdata_o` unchanged.
- R9: A read of a pointer port (base+0 or base+2) returns that pointer's current value, zero-extended to 8 bits, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| io_addr_i | input | 16 | Host I/O address |
| io_rd_i | input | 1 | Host read request, one cycle per access |
| io_wr_i | input | 1 | Host write request, one cycle per access |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Registered read data |
| vrt_i | input | 1 | Contents-valid indication shown in the status register |
| tk_sel_o | output | 1 | Data access to a routed timekeeping index |
| tk_we_o | output | 1 | Routed access is a write |
| tk_idx_o | output | 7 | Routed index |
| tk_wdata_o | output | 8 | Routed write data |
| tk_rdata_i | input | 8 | Read-back data from the timekeeping block |
| flag_clr_o | output | 1 | One-cycle strobe after a read of the flag register |

## Verification
The routing outputs `tk_sel_o`, `tk_we_o`, `tk_idx_o` and `tk_wdata_o` are combinational in the request cycle. The bench therefore samples them one time unit after it drives a request, before the clock edge that ends the access. Read data and `flag_clr_o` are registered, so both become valid one edge after the request. The bench samples them at the falling edge that follows that rising edge. The bench samples `flag_clr_o` again one cycle later to confirm that the pulse lasts a single cycle.

// File: rtl/cmos_port_pkg.sv
// Shared types for the indexed register port.
// Assumes: every index of both banks falls into exactly one target class.
package cmos_port_pkg;

    // Target class of the byte that the current data-port access reaches
    typedef enum logic [1:0] {
        TGT_STORE  = 2'd0,   // local general-purpose byte
        TGT_CLOCK  = 2'd1,   // forwarded to the timekeeping block
        TGT_STATUS = 2'd2    // local status register
    } tgt_e;

endpackage

// File: rtl/cmos_index_regs.sv
// One pointer register per bank. Each register loads on its own write
// strobe and holds its value otherwise.
// Assumes: at most one strobe is active per cycle. The caller drops any
// upper data bits beyond IDX_W.
module cmos_index_regs #(
    parameter int IDX_W = 7,
    parameter int NBANK = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_n_i,
    input  logic [NBANK-1:0]             ld_i,
    input  logic [IDX_W-1:0]             val_i,
    output logic [NBANK-1:0][IDX_W-1:0]  idx_o
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Load pointer b on its strobe, clear on reset
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                idx_o[b] <= '0;
            else if (ld_i[b])
                idx_o[b] <= val_i;
        end
    end

endmodule

// File: rtl/cmos_decode.sv
// Decodes a host I/O address into window hit, port kind and bank.
// Classifies the bank's current pointer into a target class.
// Assumes: BASE_ADDR is aligned to four bytes. The upper bank has no
// special indices.
module cmos_decode
    import cmos_port_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0070,
    parameter int                IDX_W       = 7,
    parameter int                STATUS_IDX  = 13,
    parameter int                CENTURY_IDX = 50
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [1:0][IDX_W-1:0]   idx_i,
    output logic                    hit_o,
    output logic                    data_o,
    output logic                    bank_o,
    output logic [IDX_W-1:0]        idx_o,
    output tgt_e                    tgt_o
);

    localparam logic [IDX_W-1:0] STAT_I = IDX_W'(STATUS_IDX);
    localparam logic [IDX_W-1:0] CLK_LAST_I = IDX_W'(STATUS_IDX - 1);
    localparam logic [IDX_W-1:0] CENT_I = IDX_W'(CENTURY_IDX);

    // Window compare and port split
    always_comb begin
        hit_o  = (addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
        bank_o = addr_i[1];
        data_o = addr_i[0];
        idx_o  = idx_i[addr_i[1]];
    end

    // Classify the selected index
    always_comb begin
        if (bank_o)
            tgt_o = TGT_STORE;
        else if (idx_o == STAT_I)
            tgt_o = TGT_STATUS;
        else if (idx_o <= CLK_LAST_I || idx_o == CENT_I)
            tgt_o = TGT_CLOCK;
        else
            tgt_o = TGT_STORE;
    end

endmodule

// File: rtl/cmos_store.sv
// General-purpose byte storage for both banks, addressed by {bank, index}.
// The write is synchronous, the read is combinational, and every byte
// clears on reset.
// Assumes: the caller never writes entries that it routes elsewhere.
module cmos_store #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              we_i,
    input  logic              bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 2 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W:0]    addr;

    assign addr    = {bank_i, idx_i};
    assign rdata_o = mem_q[addr];

    // Clear all bytes on reset, write one byte per strobe
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[addr] <= wdata_i;
        end
    end

endmodule

// File: rtl/cmos_port.sv
// Host-facing indexed register port. Two pointer/data pairs reach 256
// bytes. Timekeeping indices are forwarded, status is local, and the rest
// is storage. Read data and the flag-clear strobe are registered.
// Assumes: io_rd_i and io_wr_i are never high together, and each access
// lasts one cycle.
module cmos_port
    import cmos_port_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0070,
    parameter int                DATA_W      = 8,
    parameter int                IDX_W       = 7,
    parameter int                FLAG_IDX    = 12,
    parameter int                STATUS_IDX  = 13,
    parameter int                CENTURY_IDX = 50,
    parameter int                VALID_BIT   = 7
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    input  logic [DATA_W-1:0] io_wdata_i,
    output logic [DATA_W-1:0] io_rdata_o,
    input  logic              vrt_i,
    output logic              tk_sel_o,
    output logic              tk_we_o,
    output logic [IDX_W-1:0]  tk_idx_o,
    output logic [DATA_W-1:0] tk_wdata_o,
    input  logic [DATA_W-1:0] tk_rdata_i,
    output logic              flag_clr_o
);

    localparam int NBANK = 2;
    localparam logic [IDX_W-1:0] FLAG_I = IDX_W'(FLAG_IDX);

    logic [NBANK-1:0][IDX_W-1:0] idx_q;
    logic [NBANK-1:0]            idx_ld;
    logic                        hit, is_data, bank;
    logic [IDX_W-1:0]            cur_idx;
    tgt_e                        tgt;
    logic                        store_we;
    logic [DATA_W-1:0]           store_rd, rd_val, status_val;

    cmos_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W),
        .STATUS_IDX(STATUS_IDX), .CENTURY_IDX(CENTURY_IDX)
    ) u_dec (
        .addr_i(io_addr_i), .idx_i(idx_q), .hit_o(hit), .data_o(is_data),
        .bank_o(bank), .idx_o(cur_idx), .tgt_o(tgt)
    );

    // Pointer load strobes, one per bank
    always_comb begin
        for (int b = 0; b < NBANK; b++)
            idx_ld[b] = io_wr_i && hit && !is_data && (bank == b[0]);
    end

    cmos_index_regs #(.IDX_W(IDX_W), .NBANK(NBANK)) u_idx (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .ld_i(idx_ld),
        .val_i(io_wdata_i[IDX_W-1:0]), .idx_o(idx_q)
    );

    // Storage write strobe for local bytes
    assign store_we = io_wr_i && hit && is_data && (tgt == TGT_STORE);

    cmos_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .we_i(store_we), .bank_i(bank),
        .idx_i(cur_idx), .wdata_i(io_wdata_i), .rdata_o(store_rd)
    );

    // Side interface to the timekeeping block
    always_comb begin
        tk_sel_o   = (io_rd_i || io_wr_i) && hit && is_data && (tgt == TGT_CLOCK);
        tk_we_o    = tk_sel_o && io_wr_i;
        tk_idx_o   = cur_idx;
        tk_wdata_o = io_wdata_i;
    end

    // Local status value: valid flag in its bit, other bits zero
    always_comb begin
        status_val            = '0;
        status_val[VALID_BIT] = vrt_i;
    end

    // Read mux over pointer, storage, routed and status sources
    always_comb begin
        if (!is_data)
            rd_val = DATA_W'(cur_idx);
        else begin
            unique case (tgt)
                TGT_CLOCK:  rd_val = tk_rdata_i;
                TGT_STATUS: rd_val = status_val;
                default:    rd_val = store_rd;
            endcase
        end
    end

    // Register read data on in-window reads only
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            io_rdata_o <= '0;
        else if (io_rd_i && hit)
            io_rdata_o <= rd_val;
    end

    // One-cycle strobe after a lower-bank data read of the flag register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            flag_clr_o <= 1'b0;
        else
            flag_clr_o <= io_rd_i && hit && is_data && !bank && (cur_idx == FLAG_I);
    end

endmodule

// Protocol checker for cmos_port, attached by the bind below.
// Assumes: it sees only the top-level ports.
module cmos_port_chk #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h0070,
    parameter int                DATA_W     = 8,
    parameter int                IDX_W      = 7,
    parameter int                STATUS_IDX = 13
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic [ADDR_W-1:0] io_addr_i,
    input logic              io_rd_i,
    input logic              io_wr_i,
    input logic [DATA_W-1:0] io_rdata_o,
    input logic              tk_sel_o,
    input logic              tk_we_o,
    input logic [IDX_W-1:0]  tk_idx_o,
    input logic              flag_clr_o
);

    localparam logic [ADDR_W-1:0] LO_DATA = BASE_ADDR + ADDR_W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_n_i |=> (io_rdata_o == '0 && !flag_clr_o));

    // R7
    flag_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        flag_clr_o |-> ($past(io_rd_i) && $past(io_addr_i) == LO_DATA));

    // R5
    route_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tk_we_o |-> (tk_sel_o && io_wr_i));

    // R5
    route_port_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tk_sel_o |-> (io_addr_i == LO_DATA && (io_rd_i || io_wr_i)));

    // R6
    status_local_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tk_sel_o |-> (tk_idx_o != IDX_W'(STATUS_IDX)));

    // R8
    outside_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (io_rd_i && io_addr_i[ADDR_W-1:2] != BASE_ADDR[ADDR_W-1:2]) |=> $stable(io_rdata_o));

endmodule

bind cmos_port cmos_port_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX)
) u_chk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .io_addr_i(io_addr_i),
    .io_rd_i(io_rd_i), .io_wr_i(io_wr_i), .io_rdata_o(io_rdata_o),
    .tk_sel_o(tk_sel_o), .tk_we_o(tk_we_o), .tk_idx_o(tk_idx_o),
    .flag_clr_o(flag_clr_o)
);

// File: tb/tb_cmos_port.sv
// Directed bench for cmos_port. Inputs are driven on falling edges.
// Registered results are sampled on the falling edge after the capturing
// rising edge. Routing outputs are sampled 1 ns after a request is driven.
module tb_cmos_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        vrt = 1'b0;
    logic        tk_sel, tk_we, flag_clr;
    logic [6:0]  tk_idx;
    logic [7:0]  tk_wdata, tk_rdata;

    int checks = 0;
    int fails  = 0;

    logic       s_sel, s_we, s_flag;
    logic [6:0] s_idx;
    logic [7:0] s_wd, rd;

    always #10 clk = ~clk;

    // Stand-in timekeeping block: read-back is the index plus 0x40
    assign tk_rdata = {1'b0, tk_idx} + 8'h40;

    cmos_port dut (
        .clk_i(clk), .rst_n_i(rst_n), .io_addr_i(io_addr), .io_rd_i(io_rd),
        .io_wr_i(io_wr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
        .vrt_i(vrt), .tk_sel_o(tk_sel), .tk_we_o(tk_we), .tk_idx_o(tk_idx),
        .tk_wdata_o(tk_wdata), .tk_rdata_i(tk_rdata), .flag_clr_o(flag_clr)
    );

    task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", rq, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1; io_wdata = d;
        #1;
        s_sel = tk_sel; s_we = tk_we; s_idx = tk_idx; s_wd = tk_wdata;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'h0000;
        s_flag = flag_clr;
    endtask

    task automatic bus_rd(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        s_sel = tk_sel; s_we = tk_we; s_idx = tk_idx;
        @(negedge clk);
        io_rd = 1'b0; io_addr = 16'h0000;
        rd = io_rdata; s_flag = flag_clr;
    endtask

    task automatic t_reset;
        chk("R1", "rdata after reset", io_rdata, 8'h00);
        chk("R1", "flag after reset", {7'b0, flag_clr}, 8'h00);
        bus_wr(16'h0070, 8'h14); bus_rd(16'h0071);
        chk("R1", "lower byte 0x14 after reset", rd, 8'h00);
        bus_wr(16'h0072, 8'h05); bus_rd(16'h0073);
        chk("R1", "upper byte 0x05 after reset", rd, 8'h00);
    endtask

    task automatic t_index_hold;
        bus_wr(16'h0070, 8'h94);
        bus_rd(16'h0070);
        chk("R9", "pointer readback, bit7 dropped", rd, 8'h14);
        bus_wr(16'h0071, 8'hA5); bus_rd(16'h0071);
        chk("R3", "store/read idx 0x14", rd, 8'hA5);
        bus_rd(16'h0071);
        chk("R2", "pointer held over reads", rd, 8'hA5);
        bus_wr(16'h0070, 8'h15); bus_wr(16'h0071, 8'h3C); bus_rd(16'h0071);
        chk("R3", "store/read idx 0x15", rd, 8'h3C);
        bus_wr(16'h0070, 8'h14); bus_rd(16'h0071);
        chk("R3", "idx 0x14 kept", rd, 8'hA5);
        bus_wr(16'h0070, 8'h7F); bus_wr(16'h0071, 8'hC3); bus_rd(16'h0071);
        chk("R3", "last index 0x7F", rd, 8'hC3);
        bus_wr(16'h0070, 8'h14);
    endtask

    task automatic t_upper;
        bus_wr(16'h0072, 8'h14); bus_wr(16'h0073, 8'h77); bus_rd(16'h0073);
        chk("R4", "upper idx 0x14", rd, 8'h77);
        bus_rd(16'h0071);
        chk("R4", "lower idx 0x14 independent", rd, 8'hA5);
        bus_wr(16'h0072, 8'h00); bus_wr(16'h0073, 8'h11); bus_rd(16'h0073);
        chk("R4", "upper idx 0 is storage", rd, 8'h11);
        bus_wr(16'h0072, 8'h0D); bus_wr(16'h0073, 8'h22); bus_rd(16'h0073);
        chk("R4", "upper idx 13 is storage", rd, 8'h22);
        bus_rd(16'h0072);
        chk("R9", "upper pointer readback", rd, 8'h0D);
    endtask

    task automatic t_route;
        bus_wr(16'h0070, 8'h04); bus_wr(16'h0071, 8'h59);
        chk("R5", "write sel", {7'b0, s_sel}, 8'h01);
        chk("R5", "write we", {7'b0, s_we}, 8'h01);
        chk("R5", "write idx", {1'b0, s_idx}, 8'h04);
        chk("R5", "write data", s_wd, 8'h59);
        bus_rd(16'h0071);
        chk("R5", "read we low", {7'b0, s_we}, 8'h00);
        chk("R5", "read data idx 4", rd, 8'h44);
        bus_wr(16'h0070, 8'h32); bus_rd(16'h0071);
        chk("R5", "century routed", rd, 8'h72);
        bus_wr(16'h0070, 8'h0E); bus_rd(16'h0071);
        chk("R5", "idx 14 not routed", {7'b0, s_sel}, 8'h00);
    endtask

    task automatic t_status;
        vrt = 1'b1;
        bus_wr(16'h0070, 8'h0D); bus_rd(16'h0071);
        chk("R6", "status valid=1", rd, 8'h80);
        vrt = 1'b0; bus_rd(16'h0071);
        chk("R6", "status valid=0", rd, 8'h00);
        bus_wr(16'h0071, 8'hFF);
        chk("R6", "status write not routed", {7'b0, s_sel}, 8'h00);
        vrt = 1'b1; bus_rd(16'h0071);
        chk("R6", "status after write", rd, 8'h80);
    endtask

    task automatic t_flag;
        bus_wr(16'h0070, 8'h0C); bus_rd(16'h0071);
        chk("R7", "strobe after read of 12", {7'b0, s_flag}, 8'h01);
        @(negedge clk);
        chk("R7", "strobe one cycle", {7'b0, flag_clr}, 8'h00);
        bus_wr(16'h0071, 8'h00);
        chk("R7", "no strobe on write", {7'b0, s_flag}, 8'h00);
        bus_wr(16'h0072, 8'h0C); bus_rd(16'h0073);
        chk("R7", "no strobe upper 12", {7'b0, s_flag}, 8'h00);
        bus_wr(16'h0070, 8'h0B); bus_rd(16'h0071);
        chk("R7", "no strobe idx 11", {7'b0, s_flag}, 8'h00);
    endtask

    task automatic t_window;
        bus_wr(16'h0070, 8'h04);
        bus_wr(16'h0074, 8'h99);
        chk("R8", "no route outside", {7'b0, s_sel}, 8'h00);
        bus_wr(16'h0070, 8'h14);
        bus_wr(16'h006F, 8'hEE);
        bus_wr(16'h0075, 8'hEE);
        bus_rd(16'h0071);
        chk("R8", "byte and pointer unchanged", rd, 8'hA5);
        bus_rd(16'h0074);
        chk("R8", "rdata held on outside read", rd, 8'hA5);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index_hold();
        t_upper();
        t_route();
        t_status();
        t_flag();
        t_window();
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule